// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop has settled. It watches the reference pulse and the feedback pulse that feed a phase-frequency detector. A fast sample clock samples both pulses. Once per comparison cycle the block measures, in sample ticks, how far apart the two rising edges are. It does not matter which edge comes first.

Each measurement is sorted into one of three classes against a pair of thresholds: good, in between, or bad. The pair is chosen by a window select bit. The lock output rises only after a programmable run of consecutive good cycles. Once high, it stays high through in-between cycles and falls on the first single bad cycle. This hysteresis keeps the indicator from chattering when the phase error sits near the lock threshold.

A missing partner edge is treated as bad. For correct operation, the comparison period must be longer than the unlock threshold of the selected window.

Top module: `pll_lock_detect`

## Requirements
- R1: A synchronous reset clears the lock output and the run counter, so `locked` reads 0 after reset.
- R2: The distance of a cycle is the number of sample ticks from the first rising edge of either pulse to the rising edge of the other. Either order is measured the same way, and edges that coincide give a distance of 0.
- R3: A cycle is good when its distance is strictly below the lock threshold. That threshold is 4 ticks when `win_sel`=0 and 8 ticks when `win_sel`=1, so a distance equal to the threshold is not good.
- R4: While unlocked, `locked` rises after a run of consecutive good cycles whose length is set by `cnt_sel`: 0 gives 5, 1 gives 16, 2 gives 64 and 3 gives 255. `locked` goes high two sample clocks after the rising edge that completes the last good cycle.
- R5: While unlocked, any cycle that is not good resets the run to zero.
- R6: While locked, a cycle whose distance is at most the unlock threshold leaves `locked` high. The unlock threshold is 8 ticks when `win_sel`=0 and 16 ticks when `win_sel`=1.
- R7: While locked, a single cycle whose distance is above the unlock threshold drops `locked` to 0, and a new run must then begin from zero.
- R8: If the partner edge has not arrived within twice the unlock threshold after the first edge, the cycle is treated as bad.
- R9: `win_sel` selects between the two threshold pairs, 4/8 and 8/16 given as lock/unlock. The same distance can therefore be good under one window and not good under the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference pulse |
| fb_in | input | 1 | Feedback pulse |
| win_sel | input | 1 | Threshold pair select: 0 gives 4/8, 1 gives 8/16 |
| cnt_sel | input | 2 | Number of consecutive good cycles needed for lock |
| locked | output | 1 | Registered lock indicator |

## Verification
The bench builds the block with its default parameters: the 4/8 and 8/16 threshold pairs and the run lengths 5, 16, 64 and 255. With a comparison period of 50 ticks, every run length completes within the bench, including the longest one. Even a timeout of 32 ticks in window 1 finishes before the next cycle begins. The bench places edge distances exactly on each threshold and one tick either side of it. It also interrupts good runs with single in-between cycles and leaves the partner edge out entirely.

// File: rtl/pld_pkg.sv
package pld_pkg;
  // Classification of one comparison cycle
  typedef enum logic [1:0] {
    CLS_GOOD = 2'd0,
    CLS_MID  = 2'd1,
    CLS_BAD  = 2'd2
  } cls_t;
endpackage

// File: rtl/pld_edge_meas.sv
module pld_edge_meas #(
  parameter int UNLOCK_THR0 = 8,
  parameter int UNLOCK_THR1 = 16,
  parameter int DW          = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_in,
  input  logic          fb_in,
  input  logic          win_sel,
  output logic          res_valid,
  output logic [DW-1:0] res_dist,
  output logic          res_tmo
);
  typedef enum logic {MS_IDLE, MS_WAIT} mstate_t;

  localparam logic [DW-1:0] TMO0 = DW'(2 * UNLOCK_THR0);
  localparam logic [DW-1:0] TMO1 = DW'(2 * UNLOCK_THR1);

  mstate_t       st;
  logic          ref_q, fb_q, lead_ref;
  logic [DW-1:0] cnt;
  logic          rise_r, rise_f, partner;
  logic [DW-1:0] tmo_lim;

  assign rise_r  = ref_in & ~ref_q;
  assign rise_f  = fb_in & ~fb_q;
  assign partner = lead_ref ? rise_f : rise_r;
  assign tmo_lim = win_sel ? TMO1 : TMO0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= MS_IDLE;
      ref_q     <= 1'b0;
      fb_q      <= 1'b0;
      lead_ref  <= 1'b0;
      cnt       <= '0;
      res_valid <= 1'b0;
      res_dist  <= '0;
      res_tmo   <= 1'b0;
    end else begin
      ref_q     <= ref_in;
      fb_q      <= fb_in;
      res_valid <= 1'b0;
      case (st)
        MS_IDLE: begin
          if (rise_r && rise_f) begin
            res_valid <= 1'b1;
            res_dist  <= '0;
            res_tmo   <= 1'b0;
          end else if (rise_r || rise_f) begin
            st       <= MS_WAIT;
            lead_ref <= rise_r;
            cnt      <= DW'(1);
          end
        end
        default: begin
          if (partner) begin
            res_valid <= 1'b1;
            res_dist  <= cnt;
            res_tmo   <= 1'b0;
            st        <= MS_IDLE;
          end else if (cnt >= tmo_lim) begin
            res_valid <= 1'b1;
            res_dist  <= cnt;
            res_tmo   <= 1'b1;
            st        <= MS_IDLE;
          end else begin
            cnt <= cnt + DW'(1);
          end
        end
      endcase
    end
  end

  // R2: one edge of each pulse cannot finish two cycles back to back
  a_r2_one_result: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R8: the wait never runs past the timeout limit
  a_r8_wait_bound: assert property (@(posedge clk) disable iff (rst)
    (st == MS_WAIT) |-> (cnt <= tmo_lim));
endmodule

// File: rtl/pld_qualifier.sv
module pld_qualifier
  import pld_pkg::*;
#(
  parameter int LOCK_THR0   = 4,
  parameter int UNLOCK_THR0 = 8,
  parameter int LOCK_THR1   = 8,
  parameter int UNLOCK_THR1 = 16,
  parameter int RUN0        = 5,
  parameter int RUN1        = 16,
  parameter int RUN2        = 64,
  parameter int RUN3        = 255,
  parameter int DW          = 6,
  parameter int RW          = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          res_valid,
  input  logic [DW-1:0] res_dist,
  input  logic          res_tmo,
  input  logic          win_sel,
  input  logic [1:0]    cnt_sel,
  output logic          locked
);
  logic [DW-1:0] lock_thr, unlock_thr;
  logic [RW:0]   need, run_nx;
  logic [RW-1:0] run;
  cls_t          cls;

  assign lock_thr   = win_sel ? DW'(LOCK_THR1)   : DW'(LOCK_THR0);
  assign unlock_thr = win_sel ? DW'(UNLOCK_THR1) : DW'(UNLOCK_THR0);
  assign run_nx     = {1'b0, run} + 1'b1;

  always_comb begin
    case (cnt_sel)
      2'd0:    need = (RW+1)'(RUN0);
      2'd1:    need = (RW+1)'(RUN1);
      2'd2:    need = (RW+1)'(RUN2);
      default: need = (RW+1)'(RUN3);
    endcase
  end

  always_comb begin
    if (res_tmo || res_dist > unlock_thr) cls = CLS_BAD;
    else if (res_dist < lock_thr)         cls = CLS_GOOD;
    else                                  cls = CLS_MID;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      run    <= '0;
    end else if (res_valid) begin
      if (locked) begin
        if (cls == CLS_BAD) begin
          locked <= 1'b0;
          run    <= '0;
        end
      end else if (cls == CLS_GOOD) begin
        if (run_nx >= need) begin
          locked <= 1'b1;
          run    <= '0;
        end else begin
          run <= run_nx[RW-1:0];
        end
      end else begin
        run <= '0;
      end
    end
  end

  // R1: reset leaves the indicator low
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> !locked);

  // R7: a bad cycle while locked drops lock on the next clock
  a_r7_single_drop: assert property (@(posedge clk) disable iff (rst)
    (locked && res_valid && cls == CLS_BAD) |=> !locked);

  // R6: cycles that are not bad keep lock
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (locked && !(res_valid && cls == CLS_BAD)) |=> locked);

  // R4: lock only rises on a good cycle
  a_r4_rise_on_good: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(res_valid && cls == CLS_GOOD));
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int LOCK_THR0   = 4,
  parameter int UNLOCK_THR0 = 8,
  parameter int LOCK_THR1   = 8,
  parameter int UNLOCK_THR1 = 16,
  parameter int RUN0        = 5,
  parameter int RUN1        = 16,
  parameter int RUN2        = 64,
  parameter int RUN3        = 255
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_in,
  input  logic       fb_in,
  input  logic       win_sel,
  input  logic [1:0] cnt_sel,
  output logic       locked
);
  localparam int MAX_UNLOCK = (UNLOCK_THR0 > UNLOCK_THR1) ? UNLOCK_THR0 : UNLOCK_THR1;
  localparam int DW         = $clog2(2 * MAX_UNLOCK + 2);
  localparam int MAX_RUN01  = (RUN0 > RUN1) ? RUN0 : RUN1;
  localparam int MAX_RUN23  = (RUN2 > RUN3) ? RUN2 : RUN3;
  localparam int MAX_RUN    = (MAX_RUN01 > MAX_RUN23) ? MAX_RUN01 : MAX_RUN23;
  localparam int RW         = $clog2(MAX_RUN + 1);

  logic          res_valid, res_tmo;
  logic [DW-1:0] res_dist;

  pld_edge_meas #(
    .UNLOCK_THR0(UNLOCK_THR0), .UNLOCK_THR1(UNLOCK_THR1), .DW(DW)
  ) u_meas (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .win_sel(win_sel),
    .res_valid(res_valid), .res_dist(res_dist), .res_tmo(res_tmo)
  );

  pld_qualifier #(
    .LOCK_THR0(LOCK_THR0), .UNLOCK_THR0(UNLOCK_THR0),
    .LOCK_THR1(LOCK_THR1), .UNLOCK_THR1(UNLOCK_THR1),
    .RUN0(RUN0), .RUN1(RUN1), .RUN2(RUN2), .RUN3(RUN3),
    .DW(DW), .RW(RW)
  ) u_qual (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_dist(res_dist),
    .res_tmo(res_tmo), .win_sel(win_sel), .cnt_sel(cnt_sel), .locked(locked)
  );
endmodule

// File: tb/pll_lock_detect_tb.sv
module pll_lock_detect_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0;
  logic       fb_in = 1'b0;
  logic       win_sel = 1'b0;
  logic [1:0] cnt_sel = 2'd0;
  logic       locked;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pll_lock_detect u_dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .win_sel(win_sel), .cnt_sel(cnt_sel), .locked(locked)
  );

  // Behavioural reference model
  int  m_lock_tab[2]   = '{4, 8};
  int  m_unlock_tab[2] = '{8, 16};
  int  m_run_tab[4]    = '{5, 16, 64, 255};
  bit  m_rq, m_fq, m_waiting, m_lead_ref, m_locked;
  int  m_el, m_run;
  bit  p_v, p_t;
  int  p_d;

  always @(posedge clk) begin
    bit rr, fr, bad, good;
    if (rst) begin
      m_rq = 0; m_fq = 0; m_waiting = 0; m_lead_ref = 0; m_el = 0;
      m_locked = 0; m_run = 0; p_v = 0; p_t = 0; p_d = 0;
    end else begin
      if (p_v) begin
        bad  = p_t || (p_d > m_unlock_tab[win_sel]);
        good = !bad && (p_d < m_lock_tab[win_sel]);
        if (m_locked) begin
          if (bad) begin m_locked = 0; m_run = 0; end
        end else if (good) begin
          m_run++;
          if (m_run >= m_run_tab[cnt_sel]) begin m_locked = 1; m_run = 0; end
        end else m_run = 0;
      end
      p_v = 0;
      rr = ref_in && !m_rq;
      fr = fb_in && !m_fq;
      if (!m_waiting) begin
        if (rr && fr) begin p_v = 1; p_d = 0; p_t = 0; end
        else if (rr || fr) begin m_waiting = 1; m_lead_ref = rr; m_el = 0; end
      end else begin
        m_el++;
        if ((m_lead_ref && fr) || (!m_lead_ref && rr)) begin
          p_v = 1; p_d = m_el; p_t = 0; m_waiting = 0;
        end else if (m_el >= 2 * m_unlock_tab[win_sel]) begin
          p_v = 1; p_d = m_el; p_t = 1; m_waiting = 0;
        end
      end
      m_rq = ref_in;
      m_fq = fb_in;
    end
  end

  // Every-clock comparison against the model (R4 run qualification)
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_tests++;
      if (locked !== m_locked) begin
        n_fail++;
        $display("FAIL R4 model compare at %0t: locked=%0b expected=%0b", $time, locked, m_locked);
      end
    end
  end

  task automatic check(input string req, input bit exp);
    n_tests++;
    if (locked !== exp) begin
      n_fail++;
      $display("FAIL %s: locked=%0b expected=%0b", req, locked, exp);
    end
  endtask

  task automatic do_reset(input bit w, input logic [1:0] c);
    @(negedge clk);
    rst = 1; win_sel = w; cnt_sel = c; ref_in = 0; fb_in = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  // One comparison cycle of 50 ticks. d<0 leaves the partner edge out.
  task automatic one_cycle(input int d, input bit ref_first);
    int ri, fi;
    ri = ref_first ? 0 : d;
    fi = ref_first ? d : 0;
    if (d < 0) begin ri = ref_first ? 0 : -1; fi = ref_first ? -1 : 0; end
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      ref_in = (i == ri);
      fb_in  = (i == fi);
    end
  endtask

  task automatic cycles(input int n, input int d);
    for (int k = 0; k < n; k++) one_cycle(d, 1'b1);
  endtask

  initial begin
    do_reset(1'b0, 2'd0);
    check("R1 after reset", 1'b0);

    cycles(4, 2);
    check("R4 four of five good", 1'b0);
    cycles(1, 2);
    check("R4 fifth good locks", 1'b1);
    cycles(3, 6);
    check("R6 mid cycles hold lock", 1'b1);
    cycles(1, 8);
    check("R6 distance equal to unlock holds", 1'b1);
    cycles(1, 9);
    check("R7 single bad cycle drops", 1'b0);

    cycles(4, 3);
    cycles(1, 4);
    cycles(4, 3);
    check("R5 boundary mid cycle restarts run", 1'b0);
    cycles(1, 3);
    check("R5 run completes after restart", 1'b1);

    do_reset(1'b0, 2'd0);
    cycles(6, 4);
    check("R3 distance equal to lock threshold never locks", 1'b0);

    do_reset(1'b0, 2'd0);
    for (int k = 0; k < 5; k++) one_cycle(3, 1'b0);
    check("R2 feedback first locks", 1'b1);
    one_cycle(-1, 1'b0);
    check("R8 missing reference edge drops", 1'b0);
    cycles(5, 0);
    check("R2 coincident edges lock", 1'b1);
    one_cycle(-1, 1'b1);
    check("R8 missing feedback edge drops", 1'b0);

    do_reset(1'b1, 2'd0);
    cycles(5, 6);
    check("R9 window one accepts distance 6", 1'b1);
    cycles(1, 12);
    check("R9 window one mid holds", 1'b1);
    cycles(1, 16);
    check("R6 window one equal unlock holds", 1'b1);
    cycles(1, 17);
    check("R7 window one drop", 1'b0);
    cycles(5, 7);
    one_cycle(-1, 1'b1);
    check("R8 window one timeout drops", 1'b0);

    do_reset(1'b0, 2'd1);
    cycles(15, 1);
    check("R4 sel1 fifteen not enough", 1'b0);
    cycles(1, 1);
    check("R4 sel1 sixteen locks", 1'b1);
    do_reset(1'b0, 2'd2);
    cycles(63, 1);
    check("R4 sel2 63 not enough", 1'b0);
    cycles(1, 1);
    check("R4 sel2 64 locks", 1'b1);
    do_reset(1'b0, 2'd3);
    cycles(254, 1);
    check("R4 sel3 254 not enough", 1'b0);
    cycles(1, 1);
    check("R4 sel3 255 locks", 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog expired: finished=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule